// File: doc/BRIEF.md
# Program/Erase Status Register with Error Lockout

This block keeps the eight-bit status byte of a serial flash device and acts as the gate in front of the internal program/erase sequencer. The command decoder sends it start requests for program and erase operations and a clear-status request. The sequencer sends it a done pulse or a fail pulse when the running operation ends. The block decides whether each start may go ahead. It passes accepted starts to the sequencer as one-cycle go pulses and flags refused ones with a reject pulse.

The status byte reports four things. A ready/busy bit sits at bit 0. A completion bit sits at bit 7: it starts at 1, falls when an operation ends, and rises again only when a new operation is accepted or a clear is accepted. Two sticky error flags sit at bit 4 (erase) and bit 3 (program). While either error flag is set, no program or erase can start. Only the clear-status request or reset releases this lockout, and reset stands in for a power cycle. The serial front-end reads the byte straight from the status output.

Top module: `pe_status_regs`

## Requirements
- R1: After reset the status byte is 0x81 (completion bit 7 = 1, ready bit 0 = 1, all other bits 0), and prog_go_o, erase_go_o and reject_o are low.
- R2: A single start request (program on prog_req_i, erase on erase_req_i) is accepted when the block is ready and neither error flag is set. On the next cycle bit 0 is 0, bit 7 is 1, and the matching go output is high for exactly one cycle.
- R3: A done pulse while busy sets bit 0 to 1 and bit 7 to 0 on the next cycle, and leaves bits 4 and 3 unchanged.
- R4: A fail pulse while busy sets bit 0 to 1 and bit 7 to 0. It also sets bit 3 if the running operation is a program, or bit 4 if it is an erase. When done and fail arrive together, fail wins.
- R5: While bit 3 or bit 4 is set, a start request raises reject_o for one cycle, produces no go pulse, and changes no status bit.
- R6: A start request while busy is rejected with a reject_o pulse and does not disturb the running operation.
- R7: Program and erase requested in the same cycle are rejected together. At most one of prog_go_o, erase_go_o and reject_o is high in any cycle.
- R8: A clear-status request while ready clears bits 4 and 3 and sets bit 7 to 1 on the next cycle. Bit 0 stays 1.
- R9: A clear-status request while busy is ignored, and the error flags and bit 7 keep their values.
- R10: Bits 6, 5, 2 and 1 always read 0.
- R11: A done or fail pulse while ready is ignored.
- R12: When a clear and a start arrive in the same cycle while ready, the start is judged against the error flags as they stood before the clear. The clear takes effect in either case.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, models power loss |
| prog_req_i | input | 1 | Program start request from the command decoder |
| erase_req_i | input | 1 | Erase start request from the command decoder |
| op_done_i | input | 1 | Running operation finished without error |
| op_fail_i | input | 1 | Running operation finished with error |
| clr_req_i | input | 1 | Clear-status request |
| status_o | output | STATUS_W | Status byte for the serial front-end |
| prog_go_o | output | 1 | One-cycle launch of an accepted program |
| erase_go_o | output | 1 | One-cycle launch of an accepted erase |
| reject_o | output | 1 | One-cycle notice that a start request was refused |

## Verification
The embedded properties assume that the clear, done and fail inputs are sampled only on clock edges and are meaningful for a single cycle at a time. They make no assumption that the sequencer reports completion only while busy, because the design must ignore stray pulses while ready. To respect the one-cycle meaning, the directed stimulus drives each request for exactly one cycle. A random phase also drives all five inputs independently, which includes stray done/fail pulses while idle, clears during busy periods and colliding start requests. A behavioural reference model in the bench follows every one of those cycles.

// File: rtl/pe_status_pkg.sv
package pe_status_pkg;

   typedef enum logic {
      KIND_PROG  = 1'b0,
      KIND_ERASE = 1'b1
   } op_kind_e;

   localparam int unsigned KIND_COUNT = 2;

   typedef struct packed {
      logic     accept;
      logic     reject;
      op_kind_e kind;
   } start_verdict_t;

endpackage

// File: rtl/pe_start_gate.sv
module pe_start_gate
   import pe_status_pkg::*;
#(
   parameter int unsigned BUSY_POLICY = 0
) (
   input  logic [KIND_COUNT-1:0] req_vec_i,
   input  logic                  ready_i,
   input  logic                  err_any_i,
   output start_verdict_t        verdict_o
);

   logic any_req;
   logic multi_req;
   logic busy_refuse;

   assign any_req   = |req_vec_i;
   assign multi_req = (req_vec_i & (req_vec_i - 1'b1)) != '0;

   generate
      if (BUSY_POLICY == 0) begin : g_busy_reject
         assign busy_refuse = any_req & ~ready_i;
      end else begin : g_busy_drop
         assign busy_refuse = 1'b0;
      end
      if (BUSY_POLICY > 1) begin : g_bad_policy
         $error("pe_start_gate: BUSY_POLICY must be 0 or 1");
      end
   endgenerate

   always_comb begin
      verdict_o.accept = any_req & ~multi_req & ~err_any_i & ready_i;
      verdict_o.reject = any_req & ~verdict_o.accept &
                         (multi_req | err_any_i | busy_refuse);
      verdict_o.kind   = req_vec_i[KIND_ERASE] ? KIND_ERASE : KIND_PROG;
   end

endmodule

// File: rtl/pe_op_tracker.sv
module pe_op_tracker
   import pe_status_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     accept_i,
   input  op_kind_e kind_i,
   input  logic     done_i,
   input  logic     fail_i,
   input  logic     clr_i,
   output logic     ready_o,
   output logic     cmpl_o,
   output op_kind_e kind_o,
   output logic     fail_evt_o,
   output logic     clr_ok_o
);

   logic     ready_q, ready_d;
   logic     cmpl_q, cmpl_d;
   op_kind_e kind_q, kind_d;
   logic     finish;

   assign finish     = ~ready_q & (done_i | fail_i);
   assign fail_evt_o = ~ready_q & fail_i;
   assign clr_ok_o   = ready_q & clr_i;

   always_comb begin
      ready_d = ready_q;
      cmpl_d  = cmpl_q;
      kind_d  = kind_q;
      if (accept_i) begin
         ready_d = 1'b0;
         cmpl_d  = 1'b1;
         kind_d  = kind_i;
      end else if (finish) begin
         ready_d = 1'b1;
         cmpl_d  = 1'b0;
      end
      if (clr_ok_o) begin
         cmpl_d = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ready_q <= 1'b1;
         cmpl_q  <= 1'b1;
         kind_q  <= KIND_PROG;
      end else begin
         ready_q <= ready_d;
         cmpl_q  <= cmpl_d;
         kind_q  <= kind_d;
      end
   end

   assign ready_o = ready_q;
   assign cmpl_o  = cmpl_q;
   assign kind_o  = kind_q;

   // completion bit only falls at the end of a running operation
   assert_cmpl_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cmpl_q) |-> ($past(!ready_q) && $past(done_i || fail_i)));

   // stray completion pulses while ready do not move the state
   assert_idle_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (ready_q && !accept_i && !clr_i) |=> ($stable(cmpl_q) && ready_q));

endmodule

// File: rtl/pe_err_flags.sv
module pe_err_flags
   import pe_status_pkg::*;
#(
   parameter int unsigned NUM_KINDS = KIND_COUNT
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 fail_evt_i,
   input  op_kind_e             kind_i,
   input  logic                 clr_ok_i,
   input  logic                 busy_clr_i,
   output logic [NUM_KINDS-1:0] flags_o
);

   logic [NUM_KINDS-1:0] flags_q;

   generate
      if (NUM_KINDS != KIND_COUNT) begin : g_bad_kinds
         $error("pe_err_flags: NUM_KINDS must match the operation kinds");
      end
      for (genvar k = 0; k < NUM_KINDS; k++) begin : g_flag
         logic hit;
         assign hit = fail_evt_i && (int'(kind_i) == k);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               flags_q[k] <= 1'b0;
            end else if (hit) begin
               flags_q[k] <= 1'b1;
            end else if (clr_ok_i) begin
               flags_q[k] <= 1'b0;
            end
         end

         // an error flag only appears after a reported failure
         assert_flag_from_fail_R4: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flags_q[k]) |-> $past(fail_evt_i));
      end
   endgenerate

   assign flags_o = flags_q;

   // clearing while busy leaves the flags alone
   assert_busy_clear_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_clr_i && !fail_evt_i) |=> $stable(flags_q));

endmodule

// File: rtl/pe_status_regs.sv
module pe_status_regs
   import pe_status_pkg::*;
#(
   parameter int unsigned STATUS_W    = 8,
   parameter int unsigned BIT_CMPL    = 7,
   parameter int unsigned BIT_EERR    = 4,
   parameter int unsigned BIT_PERR    = 3,
   parameter int unsigned BIT_RDY     = 0,
   parameter int unsigned BUSY_POLICY = 0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                prog_req_i,
   input  logic                erase_req_i,
   input  logic                op_done_i,
   input  logic                op_fail_i,
   input  logic                clr_req_i,
   output logic [STATUS_W-1:0] status_o,
   output logic                prog_go_o,
   output logic                erase_go_o,
   output logic                reject_o
);

   localparam int unsigned MAX_BIT = STATUS_W - 1;

   generate
      if (STATUS_W < 4) begin : g_bad_width
         $error("pe_status_regs: STATUS_W too small");
      end
      if (BIT_CMPL > MAX_BIT || BIT_EERR > MAX_BIT ||
          BIT_PERR > MAX_BIT || BIT_RDY > MAX_BIT) begin : g_bad_range
         $error("pe_status_regs: status bit position out of range");
      end
      if (BIT_CMPL == BIT_EERR || BIT_CMPL == BIT_PERR || BIT_CMPL == BIT_RDY ||
          BIT_EERR == BIT_PERR || BIT_EERR == BIT_RDY || BIT_PERR == BIT_RDY) begin : g_bad_overlap
         $error("pe_status_regs: status bit positions overlap");
      end
   endgenerate

   logic [KIND_COUNT-1:0] req_vec;
   logic [KIND_COUNT-1:0] err_flags;
   start_verdict_t        verdict;
   logic                  ready;
   logic                  cmpl;
   op_kind_e              run_kind;
   logic                  fail_evt;
   logic                  clr_ok;
   logic                  pgo_q, ego_q, rej_q;

   assign req_vec[KIND_PROG]  = prog_req_i;
   assign req_vec[KIND_ERASE] = erase_req_i;

   pe_start_gate #(
      .BUSY_POLICY (BUSY_POLICY)
   ) u_gate (
      .req_vec_i (req_vec),
      .ready_i   (ready),
      .err_any_i (|err_flags),
      .verdict_o (verdict)
   );

   pe_op_tracker u_track (
      .clk        (clk),
      .rst_n      (rst_n),
      .accept_i   (verdict.accept),
      .kind_i     (verdict.kind),
      .done_i     (op_done_i),
      .fail_i     (op_fail_i),
      .clr_i      (clr_req_i),
      .ready_o    (ready),
      .cmpl_o     (cmpl),
      .kind_o     (run_kind),
      .fail_evt_o (fail_evt),
      .clr_ok_o   (clr_ok)
   );

   pe_err_flags #(
      .NUM_KINDS (KIND_COUNT)
   ) u_err (
      .clk        (clk),
      .rst_n      (rst_n),
      .fail_evt_i (fail_evt),
      .kind_i     (run_kind),
      .clr_ok_i   (clr_ok),
      .busy_clr_i (~ready & clr_req_i),
      .flags_o    (err_flags)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pgo_q <= 1'b0;
         ego_q <= 1'b0;
         rej_q <= 1'b0;
      end else begin
         pgo_q <= verdict.accept & (verdict.kind == KIND_PROG);
         ego_q <= verdict.accept & (verdict.kind == KIND_ERASE);
         rej_q <= verdict.reject;
      end
   end

   assign prog_go_o  = pgo_q;
   assign erase_go_o = ego_q;
   assign reject_o   = rej_q;

   generate
      for (genvar b = 0; b < STATUS_W; b++) begin : g_stat
         if (b == BIT_CMPL) begin : g_cmpl
            assign status_o[b] = cmpl;
         end else if (b == BIT_EERR) begin : g_eerr
            assign status_o[b] = err_flags[KIND_ERASE];
         end else if (b == BIT_PERR) begin : g_perr
            assign status_o[b] = err_flags[KIND_PROG];
         end else if (b == BIT_RDY) begin : g_rdy
            assign status_o[b] = ready;
         end else begin : g_rsvd
            assign status_o[b] = 1'b0;
         end
      end
   endgenerate

   // a launch always shows as busy with the completion bit raised
   assert_go_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (prog_go_o || erase_go_o) |-> (!status_o[BIT_RDY] && status_o[BIT_CMPL]));

   // a refusal while idle and without a clear changes nothing
   assert_reject_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (reject_o && $past(status_o[BIT_RDY]) && !$past(clr_req_i)) |-> $stable(status_o));

   // launch and refusal pulses are mutually exclusive
   assert_pulse_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({prog_go_o, erase_go_o, reject_o}));

   // an accepted clear leaves no error flag and a raised completion bit
   assert_clear_effect_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(clr_req_i && status_o[BIT_RDY]) |->
         (status_o[BIT_CMPL] && !status_o[BIT_PERR] && !status_o[BIT_EERR]));

endmodule

// File: tb/pe_status_regs_tb.sv
module pe_status_regs_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       prog_req = 1'b0, erase_req = 1'b0, done = 1'b0, fail = 1'b0, clr = 1'b0;
   logic [7:0] status;
   logic       pgo, ego, rej;

   int checks = 0;
   int fails  = 0;
   bit finished = 0;
   bit cmp_en = 0;
   string cur_req = "R1";

   // behavioural reference state
   int m_rdy = 1, m_cmpl = 1, m_perr = 0, m_eerr = 0, m_kind = 0;
   int m_pgo = 0, m_ego = 0, m_rej = 0;

   always #4 clk = ~clk;

   pe_status_regs u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .prog_req_i  (prog_req),
      .erase_req_i (erase_req),
      .op_done_i   (done),
      .op_fail_i   (fail),
      .clr_req_i   (clr),
      .status_o    (status),
      .prog_go_o   (pgo),
      .erase_go_o  (ego),
      .reject_o    (rej)
   );

   always @(posedge clk) begin
      if (!rst_n) begin
         m_rdy = 1; m_cmpl = 1; m_perr = 0; m_eerr = 0; m_kind = 0;
         m_pgo = 0; m_ego = 0; m_rej = 0;
      end else begin
         int n_rdy, n_cmpl, n_perr, n_eerr, n_kind, nreq, errs;
         n_rdy = m_rdy; n_cmpl = m_cmpl; n_perr = m_perr; n_eerr = m_eerr; n_kind = m_kind;
         m_pgo = 0; m_ego = 0; m_rej = 0;
         nreq = int'(prog_req) + int'(erase_req);
         errs = m_perr + m_eerr;
         if (nreq > 0) begin
            if (nreq == 2 || errs > 0 || m_rdy == 0) m_rej = 1;
            else begin
               n_rdy = 0; n_cmpl = 1;
               n_kind = erase_req ? 1 : 0;
               if (erase_req) m_ego = 1; else m_pgo = 1;
            end
         end
         if (m_rdy == 0 && (done || fail)) begin
            n_rdy = 1; n_cmpl = 0;
            if (fail) begin
               if (m_kind == 1) n_eerr = 1; else n_perr = 1;
            end
         end
         if (clr && m_rdy == 1) begin
            n_perr = 0; n_eerr = 0; n_cmpl = 1;
         end
         m_rdy = n_rdy; m_cmpl = n_cmpl; m_perr = n_perr; m_eerr = n_eerr; m_kind = n_kind;
      end
   end

   function automatic logic [7:0] model_byte();
      return {m_cmpl[0], 2'b00, m_eerr[0], m_perr[0], 2'b00, m_rdy[0]};
   endfunction

   task automatic check(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // compare against the model every cycle, away from the active edge
   always @(negedge clk) begin
      if (cmp_en && rst_n) begin
         check({cur_req, " status"}, status, model_byte());
         check({cur_req, " pulses"}, {pgo, ego, rej}, {m_pgo[0], m_ego[0], m_rej[0]});
         check("R10 reserved", status & 8'h66, 0);
      end
   end

   task automatic cyc(bit p, bit e, bit d, bit f, bit c);
      prog_req = p; erase_req = e; done = d; fail = f; clr = c;
      @(negedge clk);
      prog_req = 0; erase_req = 0; done = 0; fail = 0; clr = 0;
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 reset status", status, 8'h81);
      check("R1 reset pulses", {pgo, ego, rej}, 0);
      rst_n = 1;
      cmp_en = 1;
      @(negedge clk);

      cur_req = "R2";
      cyc(1, 0, 0, 0, 0);
      check("R2 program accepted", status, 8'h80);
      check("R2 program go", {pgo, ego, rej}, 3'b100);
      cyc(0, 0, 0, 0, 0);
      check("R2 go is one cycle", pgo, 0);

      cur_req = "R6";
      cyc(0, 1, 0, 0, 0);
      check("R6 start while busy rejected", rej, 1);
      check("R6 status kept busy", status, 8'h80);

      cur_req = "R3";
      cyc(0, 0, 1, 0, 0);
      check("R3 done status", status, 8'h01);

      cur_req = "R11";
      cyc(0, 0, 1, 1, 0);
      check("R11 idle pulses ignored", status, 8'h01);

      cur_req = "R4";
      cyc(0, 1, 0, 0, 0);
      check("R4 erase accepted", ego, 1);
      cyc(0, 0, 1, 1, 0);
      check("R4 fail wins, erase error", status, 8'h11);

      cur_req = "R5";
      cyc(1, 0, 0, 0, 0);
      check("R5 locked start rejected", {pgo, ego, rej}, 3'b001);
      check("R5 status unchanged", status, 8'h11);

      cur_req = "R8";
      cyc(0, 0, 0, 0, 1);
      check("R8 clear idle", status, 8'h81);

      cur_req = "R9";
      cyc(1, 0, 0, 0, 0);
      cyc(0, 0, 0, 1, 0);
      check("R4 program error", status, 8'h09);
      cyc(0, 0, 0, 0, 1);
      cyc(0, 1, 0, 0, 0);
      cyc(0, 0, 0, 0, 1);
      check("R9 clear while busy ignored", status, 8'h80);
      cyc(0, 0, 0, 1, 0);
      check("R9 errors intact", status, 8'h11);

      cur_req = "R12";
      cyc(1, 0, 0, 0, 1);
      check("R12 start judged before clear", rej, 1);
      check("R12 clear still applied", status, 8'h81);
      cyc(1, 0, 0, 0, 1);
      check("R12 clean start with clear", status, 8'h80);
      cyc(0, 0, 1, 0, 0);

      cur_req = "R7";
      cyc(1, 1, 0, 0, 0);
      check("R7 double request rejected", {pgo, ego, rej}, 3'b001);
      check("R7 status unchanged", status, 8'h01);

      cur_req = "R4";
      for (int i = 0; i < 4000; i++) begin
         cyc($urandom_range(0, 5) == 0, $urandom_range(0, 5) == 0,
             $urandom_range(0, 4) == 0, $urandom_range(0, 6) == 0,
             $urandom_range(0, 7) == 0);
      end

      cur_req = "R1";
      rst_n = 0;
      cmp_en = 0;
      @(negedge clk);
      check("R1 reset mid-run", status, 8'h81);
      finish_run();
   end

endmodule